// File: doc/BRIEF.md
# Transport Stream Sync Locker

The block takes a broadcast transport stream from a tuner front end, either one byte per sample on an 8-bit bus or one bit per sample on a serial line, and finds where each packet begins. It watches for a programmable sync token and compares it against the configured packet length. The stream is declared locked only after a run of correctly spaced tokens. Lock is dropped only after a run of missed tokens. Both run lengths are configurable.

While locked, every packet whose first byte is the token goes into an internal buffer and is then delivered on a valid/ready byte interface. Start and end flags mark the first and last byte of each packet, and the first byte is always the token. The caller can choose the sample strobe that belongs to either edge of the tuner clock, and the strobe on the other edge is ignored. The block reports its lock state and counts how many times lock has been lost.

The configuration inputs normally come from registers. Their usual values are token 0x47, packet length 188, and lock and drop thresholds of 9.

Top module: `ts_sync_locker`

## Requirements
- R1: In parallel mode (`serial_mode_i`=0) each qualified strobe delivers the byte on `par_data_i` to the framer.
- R2: In serial mode (`serial_mode_i`=1) each qualified strobe shifts in one bit, most significant bit first. While hunting, the byte boundary is realigned on any bit at which the last 8 bits equal the token.
- R3: `edge_inv_i`=0 qualifies samples with `rise_stb_i`; `edge_inv_i`=1 qualifies them with `fall_stb_i`. The strobe not selected has no effect.
- R4: Lock (`locked_o`=1) is declared at the `lock_thr_i`-th consecutive token spaced exactly `pkt_len_i` bytes apart. A threshold of 0 behaves as 1. The packet starting at that token is the first one emitted.
- R5: While locked, a packet-start position whose byte differs from the token counts as a miss, and a token clears the miss run. When the miss run reaches `drop_thr_i`, lock is dropped and `loss_cnt_o` increments by one.
- R6: Each emitted packet is exactly `pkt_len_i` bytes long. Its first byte equals `token_i` and carries `out_sop_o`=1, and its last byte carries `out_eop_o`=1.
- R7: A packet period whose start byte is not the token emits nothing, so no misaligned or partial packet reaches the output.
- R8: No byte is emitted while unlocked, including during the tokens that lead up to lock.
- R9: While `out_valid_o`=1 and `out_ready_i`=0, the output beat holds stable, and no stored byte is lost.
- R10: A packet is accepted only if the buffer (`FIFO_DEPTH` bytes) has room for all `pkt_len_i` bytes at its start. Otherwise the whole packet is skipped.
- R11: After reset `locked_o`=0, `out_valid_o`=0 and `loss_cnt_o`=0.
- R12: The token value is taken from `token_i`, so any byte value can serve as the sync token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serial_mode_i | input | 1 | 1 selects serial bit input, 0 selects byte input |
| edge_inv_i | input | 1 | 1 selects the falling-edge strobe |
| rise_stb_i | input | 1 | Sample strobe for the rising tuner clock edge |
| fall_stb_i | input | 1 | Sample strobe for the falling tuner clock edge |
| par_data_i | input | 8 | Byte-wide stream data |
| ser_data_i | input | 1 | Serial stream data |
| token_i | input | 8 | Sync token value |
| pkt_len_i | input | LEN_W | Packet length in bytes |
| lock_thr_i | input | CNT_W | Good tokens needed to lock |
| drop_thr_i | input | CNT_W | Missed tokens needed to drop lock |
| out_valid_o | output | 1 | Output beat available |
| out_ready_i | input | 1 | Downstream accepts the beat |
| out_data_o | output | 8 | Output byte |
| out_sop_o | output | 1 | First byte of a packet |
| out_eop_o | output | 1 | Last byte of a packet |
| locked_o | output | 1 | Sync lock state |
| loss_cnt_o | output | LOSS_W | Number of lock-loss events |

## Verification
Clean streams are fed in byte and serial form, on both strobe edges, with two token values and packet lengths of 4, 8, 12, 16 and 188. The count of packets that come out shows that the lock threshold is applied exactly. Junk strobes on the unselected edge would add false tokens or bits, so a wrong edge choice shows up as extra or broken packets. Serial streams start with an odd number of idle bits, which separates bit realignment from fixed byte framing. A directed run of bad, good and bad packet starts shows whether the miss run resets and where the drop point falls. A long burst under backpressure fills the buffer exactly, which tests both the whole-packet admission rule and output stability.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef struct packed {
    logic       sop;
    logic       eop;
    logic [7:0] data;
  } ts_beat_t;
endpackage

// File: rtl/ts_byte_in.sv
module ts_byte_in (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic       serial_i,
  input  logic [7:0] par_i,
  input  logic       ser_i,
  input  logic       hunt_i,
  input  logic [7:0] token_i,
  output logic       vld_o,
  output logic [7:0] byte_o
);
  logic [6:0] sh_q;
  logic [2:0] bcnt_q;
  logic [7:0] win;

  assign win = {sh_q, ser_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcnt_q <= '0;
      vld_o  <= 1'b0;
      byte_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (stb_i) begin
        if (serial_i) begin
          sh_q <= win[6:0];
          // realign on token while hunting
          if (bcnt_q == 3'd7 || (hunt_i && win == token_i)) begin
            vld_o  <= 1'b1;
            byte_o <= win;
            bcnt_q <= '0;
          end else begin
            bcnt_q <= bcnt_q + 3'd1;
          end
        end else begin
          vld_o  <= 1'b1;
          byte_o <= par_i;
        end
      end
    end
  end

  a_r1_byte_per_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !serial_i) |=> (vld_o && byte_o == $past(par_i)));

  a_r2_serial_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $past(serial_i)) |-> $past(stb_i));
endmodule

// File: rtl/ts_framer.sv
module ts_framer
  import ts_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 4,
  parameter int LOSS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [7:0]        token_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [CNT_W-1:0]  lock_thr_i,
  input  logic [CNT_W-1:0]  drop_thr_i,
  input  logic              room_i,
  output logic              hunt_o,
  output logic              locked_o,
  output logic [LOSS_W-1:0] loss_cnt_o,
  output logic              wr_en_o,
  output ts_beat_t          wr_ent_o
);
  logic              locked_q, cap_q;
  logic [CNT_W-1:0]  good_q, miss_q;
  logic [LEN_W-1:0]  pos_q;
  logic [LOSS_W-1:0] loss_q;
  logic [CNT_W:0]    good_nx, miss_nx;
  logic              tok, tracking, slot, last, lock_now, start;

  assign tok      = byte_i == token_i;
  assign tracking = locked_q || (good_q != '0);
  assign slot     = pos_q == '0;
  assign last     = pos_q == (pkt_len_i - LEN_W'(1));
  assign good_nx  = {1'b0, good_q} + (CNT_W+1)'(1);
  assign miss_nx  = {1'b0, miss_q} + (CNT_W+1)'(1);
  assign lock_now = !locked_q && slot && tok && (good_nx >= {1'b0, lock_thr_i});
  assign start    = slot && tok && (locked_q || lock_now) && room_i;

  assign wr_en_o       = byte_vld_i && (start || (!slot && cap_q));
  assign wr_ent_o.sop  = slot;
  assign wr_ent_o.eop  = last;
  assign wr_ent_o.data = byte_i;
  assign hunt_o        = !tracking;
  assign locked_o      = locked_q;
  assign loss_cnt_o    = loss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      cap_q    <= 1'b0;
      good_q   <= '0;
      miss_q   <= '0;
      pos_q    <= '0;
      loss_q   <= '0;
    end else if (byte_vld_i && (tracking || tok)) begin
      pos_q <= last ? '0 : pos_q + LEN_W'(1);
      if (slot) begin
        cap_q <= start && !last;
        if (tok) begin
          miss_q <= '0;
          if (lock_now) begin
            locked_q <= 1'b1;
            good_q   <= '0;
          end else if (!locked_q) begin
            good_q <= good_nx[CNT_W-1:0];
          end
        end else if (locked_q) begin
          if (miss_nx >= {1'b0, drop_thr_i}) begin
            locked_q <= 1'b0;
            miss_q   <= '0;
            loss_q   <= loss_q + LOSS_W'(1);
            pos_q    <= '0;
          end else begin
            miss_q <= miss_nx[CNT_W-1:0];
          end
        end else begin
          // candidate failed: back to hunting
          good_q <= '0;
          pos_q  <= '0;
        end
      end else if (last) begin
        cap_q <= 1'b0;
      end
    end
  end

  a_r4_lock_on_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(byte_vld_i && byte_i == token_i));

  a_r5_loss_counted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> loss_q == $past(loss_q) + LOSS_W'(1));

  a_r6_sop_is_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_ent_o.sop) |-> byte_i == token_i);

  a_r8_quiet_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !locked_q) |-> wr_ent_o.sop);
endmodule

// File: rtl/ts_pkt_buf.sv
module ts_pkt_buf
  import ts_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  ts_beat_t         wr_ent_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  output logic             room_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output ts_beat_t         rd_ent_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  ts_beat_t        mem [DEPTH];
  logic [PW-1:0]   wr_q, rd_q, cnt, free;

  assign cnt        = wr_q - rd_q;
  assign free       = PW'(DEPTH) - cnt;
  assign room_o     = free >= PW'(pkt_len_i);
  assign rd_valid_o = cnt != '0;
  assign rd_ent_o   = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_q[AW-1:0]] <= wr_ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (wr_en_i) wr_q <= wr_q + PW'(1);
      if (rd_valid_o && rd_ready_i) rd_q <= rd_q + PW'(1);
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> cnt < PW'(DEPTH));

  a_r9_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_ent_o)));
endmodule

// File: rtl/ts_sync_locker.sv
module ts_sync_locker
  import ts_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int CNT_W      = 4,
  parameter int LOSS_W     = 8,
  parameter int FIFO_DEPTH = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_mode_i,
  input  logic              edge_inv_i,
  input  logic              rise_stb_i,
  input  logic              fall_stb_i,
  input  logic [7:0]        par_data_i,
  input  logic              ser_data_i,
  input  logic [7:0]        token_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [CNT_W-1:0]  lock_thr_i,
  input  logic [CNT_W-1:0]  drop_thr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              locked_o,
  output logic [LOSS_W-1:0] loss_cnt_o
);
  logic       stb, byte_vld, hunt, room, wr_en;
  logic [7:0] byte_d;
  ts_beat_t   wr_ent, rd_ent;

  assign stb = edge_inv_i ? fall_stb_i : rise_stb_i;

  ts_byte_in u_in (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (stb),
    .serial_i (serial_mode_i),
    .par_i    (par_data_i),
    .ser_i    (ser_data_i),
    .hunt_i   (hunt),
    .token_i  (token_i),
    .vld_o    (byte_vld),
    .byte_o   (byte_d)
  );

  ts_framer #(.LEN_W(LEN_W), .CNT_W(CNT_W), .LOSS_W(LOSS_W)) u_frm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_d),
    .token_i    (token_i),
    .pkt_len_i  (pkt_len_i),
    .lock_thr_i (lock_thr_i),
    .drop_thr_i (drop_thr_i),
    .room_i     (room),
    .hunt_o     (hunt),
    .locked_o   (locked_o),
    .loss_cnt_o (loss_cnt_o),
    .wr_en_o    (wr_en),
    .wr_ent_o   (wr_ent)
  );

  ts_pkt_buf #(.DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_ent_i   (wr_ent),
    .pkt_len_i  (pkt_len_i),
    .room_o     (room),
    .rd_valid_o (out_valid_o),
    .rd_ready_i (out_ready_i),
    .rd_ent_o   (rd_ent)
  );

  assign out_data_o = rd_ent.data;
  assign out_sop_o  = rd_ent.sop;
  assign out_eop_o  = rd_ent.eop;
endmodule

// File: tb/sim_ts_sync_locker.sv
module sim_ts_sync_locker;
  localparam int CLK_PERIOD = 10;
  localparam int RXN = 4096;

  typedef struct packed {
    logic       ser;
    logic       inv;
    logic [7:0] tok;
    logic [7:0] len;
    logic [3:0] lk;
    logic [3:0] dr;
    logic [7:0] npk;
    logic [7:0] exp;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{1'b0, 1'b0, 8'h47, 8'd8,   4'd9, 4'd9, 8'd12, 8'd4},
    '{1'b0, 1'b1, 8'h47, 8'd16,  4'd3, 4'd2, 8'd6,  8'd4},
    '{1'b1, 1'b0, 8'h47, 8'd8,   4'd2, 4'd2, 8'd5,  8'd4},
    '{1'b1, 1'b1, 8'hB8, 8'd12,  4'd4, 4'd3, 8'd6,  8'd3},
    '{1'b0, 1'b0, 8'hB8, 8'd188, 4'd9, 4'd9, 8'd10, 8'd2},
    '{1'b0, 1'b0, 8'h47, 8'd4,   4'd1, 4'd1, 8'd3,  8'd3}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ser_mode = 1'b0, inv = 1'b0, rise = 1'b0, fall = 1'b0;
  logic [7:0] par = '0;
  logic       ser = 1'b0;
  logic [7:0] tok = 8'h47;
  logic [7:0] len = 8'd188;
  logic [3:0] lk = 4'd9, dr = 4'd9;
  logic       rdy = 1'b1;
  logic       out_valid, out_sop, out_eop, locked;
  logic [7:0] out_data, loss;

  ts_sync_locker u0 (
    .clk_i(clk), .rst_ni(rst_n), .serial_mode_i(ser_mode), .edge_inv_i(inv),
    .rise_stb_i(rise), .fall_stb_i(fall), .par_data_i(par), .ser_data_i(ser),
    .token_i(tok), .pkt_len_i(len), .lock_thr_i(lk), .drop_thr_i(dr),
    .out_valid_o(out_valid), .out_ready_i(rdy), .out_data_o(out_data),
    .out_sop_o(out_sop), .out_eop_o(out_eop), .locked_o(locked), .loss_cnt_o(loss)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] rx_d [RXN];
  logic       rx_s [RXN];
  logic       rx_e [RXN];
  int rx_n = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && rdy) begin
      if (rx_n < RXN) begin
        rx_d[rx_n] = out_data;
        rx_s[rx_n] = out_sop;
        rx_e[rx_n] = out_eop;
      end
      rx_n++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string msg, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, expv);
    end
  endtask

  function automatic logic [7:0] pl(input int i);
    return 8'((i * 5) & 'h3F);
  endfunction

  task automatic sel_stb(input logic v);
    if (inv) fall = v; else rise = v;
  endtask

  task automatic oth_stb(input logic v);
    if (inv) rise = v; else fall = v;
  endtask

  task automatic send_byte(input logic [7:0] b);
    tick(); par = b; sel_stb(1'b1);
    tick(); sel_stb(1'b0);
    if (inv) begin par = tok; oth_stb(1'b1); tick(); oth_stb(1'b0); end
    tick();
  endtask

  task automatic send_bit(input logic b);
    tick(); ser = b; sel_stb(1'b1);
    tick(); sel_stb(1'b0);
    if (inv) begin ser = ~b; oth_stb(1'b1); tick(); oth_stb(1'b0); end
    tick(); tick();
  endtask

  task automatic send_unit(input logic [7:0] b);
    if (ser_mode) for (int k = 7; k >= 0; k--) send_bit(b[k]);
    else send_byte(b);
  endtask

  task automatic send_pkt(input bit good);
    send_unit(good ? tok : 8'h00);
    for (int i = 1; i < int'(len); i++) send_unit(pl(i));
  endtask

  task automatic do_reset();
    tick(); rst_n = 1'b0; rise = 0; fall = 0; par = '0; ser = 0;
    repeat (3) tick();
    rx_n = 0;
    rst_n = 1'b1;
    tick();
  endtask

  task automatic check_pkts(input int expp, input string tag);
    int nb, bad, idx;
    logic [7:0] ed;
    nb = expp * int'(len);
    chk(rx_n == nb, {tag, " byte count"}, rx_n, nb);
    bad = -1;
    for (int k = 0; k < rx_n && k < RXN; k++) begin
      idx = k % int'(len);
      ed = (idx == 0) ? tok : pl(idx);
      if (bad < 0 && (rx_d[k] != ed || rx_s[k] != (idx == 0) || rx_e[k] != (idx == int'(len) - 1)))
        bad = k;
    end
    chk(bad < 0, {tag, " packet content at byte"}, bad, -1);
  endtask

  initial begin
    // R11: reset state
    do_reset();
    chk(locked == 1'b0, "R11 locked after reset", int'(locked), 0);
    chk(out_valid == 1'b0, "R11 valid after reset", int'(out_valid), 0);
    chk(loss == 8'd0, "R11 loss count after reset", int'(loss), 0);

    // table walk: R1 R2 R3 R4 R6 R12
    for (int r = 0; r < 6; r++) begin
      ser_mode = ROWS[r].ser; inv = ROWS[r].inv; tok = ROWS[r].tok;
      len = ROWS[r].len; lk = ROWS[r].lk; dr = ROWS[r].dr; rdy = 1'b1;
      do_reset();
      if (ser_mode) for (int k = 0; k < 3; k++) send_bit(1'b0);
      else begin send_byte(8'h00); send_byte(8'h00); end
      for (int p = 0; p < int'(ROWS[r].npk); p++) send_pkt(1'b1);
      repeat (40) tick();
      check_pkts(int'(ROWS[r].exp), $sformatf("R1/R2/R3/R4/R6/R12 row %0d", r));
      chk(locked == 1'b1, $sformatf("R4 locked row %0d", r), int'(locked), 1);
      chk(loss == 8'd0, $sformatf("R5 no loss row %0d", r), int'(loss), 0);
    end

    // directed: miss run, drop, relock
    ser_mode = 0; inv = 0; tok = 8'h47; len = 8'd8; lk = 4'd2; dr = 4'd3; rdy = 1'b1;
    do_reset();
    for (int p = 0; p < 4; p++) send_pkt(1'b1);
    send_pkt(1'b0); send_pkt(1'b0); send_pkt(1'b1); send_pkt(1'b0); send_pkt(1'b0);
    repeat (20) tick();
    chk(locked == 1'b1, "R5 miss run reset by token", int'(locked), 1);
    chk(loss == 8'd0, "R5 no loss before threshold", int'(loss), 0);
    send_pkt(1'b0);
    repeat (20) tick();
    chk(locked == 1'b0, "R5 lock dropped at threshold", int'(locked), 0);
    chk(loss == 8'd1, "R5 loss count", int'(loss), 1);
    check_pkts(4, "R7 bad starts emit nothing");
    send_pkt(1'b1);
    repeat (20) tick();
    chk(rx_n == 32, "R8 no output while unlocked", rx_n, 32);
    chk(locked == 1'b0, "R8 still unlocked", int'(locked), 0);
    send_pkt(1'b1);
    repeat (20) tick();
    chk(locked == 1'b1, "R4 relock", int'(locked), 1);
    check_pkts(5, "R4 relock emits");

    // directed: backpressure and admission
    lk = 4'd1; dr = 4'd9; rdy = 1'b0;
    do_reset();
    for (int p = 0; p < 70; p++) send_pkt(1'b1);
    repeat (10) tick();
    chk(out_valid == 1'b1 && out_sop == 1'b1 && out_data == 8'h47, "R9 head beat held", int'(out_data), 'h47);
    repeat (10) tick();
    chk(out_valid == 1'b1 && out_data == 8'h47, "R9 head beat stable", int'(out_data), 'h47);
    rdy = 1'b1;
    repeat (600) tick();
    check_pkts(64, "R10 whole packets admitted only");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule